// File: doc/BRIEF.md
# OTP Fuse Controller with Shadow Registers

The block fronts a one-time-programmable fuse array of `NWORDS` 32-bit words (96 by default) and keeps a 32-bit shadow copy of every word that software reads and writes directly over a simple register port. Writing the command register starts one of three operations: reload a word from its fuses into its shadow, program (OR) the program-data register into a fuse word, or program a row of the permanent-lock fuses. The fuse array must be powered through a request and acknowledge handshake before any command is accepted. While an operation runs, a status flag reports busy. A refused program sets a program-fail flag.

Per-word bitmaps control and report access. Three sticky lock maps, set by software and cleared only by reset, block programming, shadow writes and shadow reloads for individual words. A global lock register can block all programming. A permanent-lock map is decoded from the lock fuses. An error map marks words whose command was rejected. A disturbed map marks words whose reload was forced to zero.

Two state machines do the work. The power machine has the states OFF, RAMP_UP, ON and RAMP_DOWN. It moves OFF→RAMP_UP when power is requested, RAMP_UP→ON after the delay, RAMP_UP→OFF if the request is withdrawn, ON→RAMP_DOWN when the request drops, RAMP_DOWN→OFF after the delay, and RAMP_DOWN→ON if power is requested again. The command machine has the states IDLE, RUN and DONE. It moves IDLE→RUN on an accepted command, RUN→DONE when the busy counter expires, and DONE→IDLE. The result of the operation is committed on the DONE→IDLE edge.

Top module: `otp_shadow_ctrl`

## Requirements
- R1: After reset, every register, bitmap and shadow word reads zero. The status register reads zero: busy is bit 3, program fail is bit 4 and powered is bit 5.
- R2: Setting bit 0 of the configuration register (0x000) raises the powered status bit PWR_DLY+1 cycles after the write. Clearing bit 0 drops the powered bit PWR_DLY+1 cycles after the write.
- R3: Shadow word n is read and written at byte address 0x200+4n. A write is ignored when word n's bit in the shadow-write sticky lock map (0x07C) is set.
- R4: A reload copies fuse word n into shadow n and clears disturbed bit n (map at 0x01C). When word n's bit in the shadow-reload sticky lock map (0x094) is set, the reload loads zero into the shadow instead and sets disturbed bit n.
- R5: A command word written to 0x004 carries the index in bits 6:0. Bit 9 set selects lock, bit 8 alone selects program, and neither selects reload. An accepted command holds the busy bit for BUSY_CYC+1 cycles.
- R6: A program ORs the program-data register (0x008) into fuse word n, so fuse bits are never cleared. The shadow is not updated until a reload.
- R7: A program is refused, leaving the fuse unchanged and setting the fail bit, when word n is set in the program sticky lock map (0x064), when bit 4 of the global lock register (0x010) is set, or when word n is permanently locked.
- R8: A lock command with index r ORs program-data bits 15:0 into lock row r. The permanent-lock map at 0x04C reports word n locked under either of two rules. For n<32, the 2-bit field at row n/8, shift (2n)&15, must be nonzero. For n≥32, bit n&15 of row 4+(n−32)/16 must be set.
- R9: A command issued while unpowered or busy is rejected. Busy is never asserted for it, and error bit n (map at 0x034) is set. An accepted command on word n clears error bit n.
- R10: Writing ones to a sticky lock map or to the global lock register sets those bits. Writing zeros never clears them, and only reset does.
- R11: In every per-word map, word n is bit n&31 of the bank at map offset + 4·(n>>5).
- R12: The program-fail bit stays set until the next command is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when set together with bus_en |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest situations to reach from the ports are a second command arriving while the first is still running, and a reload or program landing on a word that an earlier random lock write has already covered. Directed steps issue a command during an open busy window and program a word after its permanent lock has been fused. A seeded random loop interleaves shadow writes, programs, reloads and occasional sticky-lock writes across all 96 words. A bench model predicts every shadow value, the fail flag and the map banks.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 7;

    localparam logic [ADDR_W-1:0] A_CFG    = 12'h000;
    localparam logic [ADDR_W-1:0] A_CMD    = 12'h004;
    localparam logic [ADDR_W-1:0] A_PDATA  = 12'h008;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h00C;
    localparam logic [ADDR_W-1:0] A_GLOCK  = 12'h010;
    localparam logic [ADDR_W-1:0] A_DIST   = 12'h01C;
    localparam logic [ADDR_W-1:0] A_ERR    = 12'h034;
    localparam logic [ADDR_W-1:0] A_PERM   = 12'h04C;
    localparam logic [ADDR_W-1:0] A_SPL    = 12'h064;
    localparam logic [ADDR_W-1:0] A_SWL    = 12'h07C;
    localparam logic [ADDR_W-1:0] A_SRL    = 12'h094;
    localparam logic [ADDR_W-1:0] A_SHADOW = 12'h200;

    localparam int CMD_PROG_BIT = 8;
    localparam int CMD_LOCK_BIT = 9;
    localparam int GL_PROG_BIT  = 4;

    typedef enum logic [1:0] {OP_RELOAD, OP_PROGRAM, OP_LOCK} op_e;
    typedef enum logic [1:0] {P_OFF, P_RAMP_UP, P_ON, P_RAMP_DOWN} pwr_st_e;
    typedef enum logic [1:0] {C_IDLE, C_RUN, C_DONE} cmd_st_e;

    function automatic int lock_rows(input int nw);
        return (nw <= 32) ? (nw + 7) / 8 : 4 + (nw - 32 + 15) / 16;
    endfunction
endpackage

// File: rtl/otp_pwr_fsm.sv
module otp_pwr_fsm
    import otp_pkg::*;
#(
    parameter int PWR_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic powered
);
    localparam int CW = $clog2(PWR_DLY + 1);

    pwr_st_e        st, st_n;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= P_OFF;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (st_n != st)  cnt <= CW'(PWR_DLY - 1);
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            P_OFF:       if (req) st_n = P_RAMP_UP;
            P_RAMP_UP:   if (!req) st_n = P_OFF;
                         else if (cnt == '0) st_n = P_ON;
            P_ON:        if (!req) st_n = P_RAMP_DOWN;
            P_RAMP_DOWN: if (req) st_n = P_ON;
                         else if (cnt == '0) st_n = P_OFF;
            default:     st_n = P_OFF;
        endcase
    end

    always_comb begin
        powered = (st == P_ON) || (st == P_RAMP_DOWN);
    end
endmodule

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
    import otp_pkg::*;
#(
    parameter int NWORDS   = 96,
    parameter int BUSY_CYC = 4,
    parameter int LROWS    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [31:0]      cmd_val,
    input  logic             powered,
    output logic             busy,
    output logic             finish,
    output logic             acc,
    output logic             rej,
    output logic [IDX_W-1:0] new_idx,
    output op_e              cur_op,
    output logic [IDX_W-1:0] cur_idx
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    cmd_st_e        st, st_n;
    logic [CW-1:0]  cnt;
    op_e            op_in;
    logic           in_range;
    logic           unused_bits;

    assign unused_bits = ^{cmd_val[31:10], cmd_val[7]};

    always_comb begin
        op_in    = cmd_val[CMD_LOCK_BIT] ? OP_LOCK :
                   cmd_val[CMD_PROG_BIT] ? OP_PROGRAM : OP_RELOAD;
        in_range = (op_in == OP_LOCK) ? (32'(cmd_val[6:0]) < LROWS)
                                      : (32'(cmd_val[6:0]) < NWORDS);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_op  <= OP_RELOAD;
            cur_idx <= '0;
        end else if (acc) begin
            cnt     <= CW'(BUSY_CYC - 1);
            cur_op  <= op_in;
            cur_idx <= cmd_val[6:0];
        end else if (st == C_RUN && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            C_IDLE:  if (acc) st_n = C_RUN;
            C_RUN:   if (cnt == '0) st_n = C_DONE;
            C_DONE:  st_n = C_IDLE;
            default: st_n = C_IDLE;
        endcase
    end

    always_comb begin
        busy    = (st != C_IDLE);
        finish  = (st == C_DONE);
        acc     = cmd_wr && in_range && (st == C_IDLE) && powered;
        rej     = cmd_wr && in_range && !((st == C_IDLE) && powered);
        new_idx = cmd_val[6:0];
    end
endmodule

// File: rtl/otp_shadow_ctrl.sv
module otp_shadow_ctrl
    import otp_pkg::*;
#(
    parameter int NWORDS   = 96,
    parameter int BUSY_CYC = 4,
    parameter int PWR_DLY  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int NBANKS = (NWORDS + 31) / 32;
    localparam int BMW    = NBANKS * 32;
    localparam int LROWS  = lock_rows(NWORDS);
    localparam int LR_W   = $clog2(LROWS);
    localparam logic [ADDR_W-1:0] SH_END = A_SHADOW + ADDR_W'(4 * NWORDS);

    logic [31:0]      shadow [NWORDS];
    logic [31:0]      fuse   [NWORDS];
    logic [15:0]      lrow   [LROWS];
    logic [BMW-1:0]   sp_lock, sw_lock, sr_lock, err_map, dist_map, perm_map;
    logic             pwr_cfg, fail;
    logic [31:0]      glock, pdata;

    logic             wr, sh_sel, sh_wr, cmd_wr;
    logic [IDX_W-1:0] sh_idx;
    logic             powered, busy, finish, acc, rej;
    logic [IDX_W-1:0] new_idx, cur_idx;
    op_e              cur_op;
    logic             refuse;

    always_comb begin
        wr     = bus_en && bus_we;
        sh_sel = (bus_addr >= A_SHADOW) && (bus_addr < SH_END) && (bus_addr[1:0] == 2'b00);
        sh_idx = IDX_W'((bus_addr - A_SHADOW) >> 2);
        sh_wr  = wr && sh_sel;
        cmd_wr = wr && (bus_addr == A_CMD);
        refuse = sp_lock[cur_idx] || glock[GL_PROG_BIT] || perm_map[cur_idx];
    end

    otp_pwr_fsm #(.PWR_DLY(PWR_DLY)) u_pwr (
        .clk(clk), .rst_n(rst_n), .req(pwr_cfg), .powered(powered)
    );

    otp_cmd_fsm #(.NWORDS(NWORDS), .BUSY_CYC(BUSY_CYC), .LROWS(LROWS)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_val(bus_wdata),
        .powered(powered), .busy(busy), .finish(finish), .acc(acc), .rej(rej),
        .new_idx(new_idx), .cur_op(cur_op), .cur_idx(cur_idx)
    );

    // Permanent-lock map decoded from the lock fuse rows (two densities)
    for (genvar n = 0; n < BMW; n++) begin : g_perm
        if (n >= NWORDS) begin : g_pad
            assign perm_map[n] = 1'b0;
        end else if (n < 32) begin : g_low
            assign perm_map[n] = |lrow[n / 8][(2 * n) % 16 +: 2];
        end else begin : g_high
            assign perm_map[n] = lrow[4 + (n - 32) / 16][n % 16];
        end
    end

    // Software-set registers and sticky maps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_cfg <= 1'b0;
            glock   <= '0;
            pdata   <= '0;
            sp_lock <= '0;
            sw_lock <= '0;
            sr_lock <= '0;
        end else if (wr) begin
            if (bus_addr == A_CFG)   pwr_cfg <= bus_wdata[0];
            if (bus_addr == A_PDATA) pdata   <= bus_wdata;
            if (bus_addr == A_GLOCK) glock   <= glock | bus_wdata;
            for (int b = 0; b < NBANKS; b++) begin
                if (bus_addr == A_SPL + ADDR_W'(4 * b))
                    sp_lock[b*32 +: 32] <= sp_lock[b*32 +: 32] | bus_wdata;
                if (bus_addr == A_SWL + ADDR_W'(4 * b))
                    sw_lock[b*32 +: 32] <= sw_lock[b*32 +: 32] | bus_wdata;
                if (bus_addr == A_SRL + ADDR_W'(4 * b))
                    sr_lock[b*32 +: 32] <= sr_lock[b*32 +: 32] | bus_wdata;
            end
        end
    end

    // Shadow, fuses and command results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) begin
                shadow[i] <= '0;
                fuse[i]   <= '0;
            end
            for (int r = 0; r < LROWS; r++) lrow[r] <= '0;
            err_map  <= '0;
            dist_map <= '0;
            fail     <= 1'b0;
        end else begin
            if (sh_wr && !sw_lock[sh_idx]) shadow[sh_idx] <= bus_wdata;
            if (rej) err_map[new_idx] <= 1'b1;
            if (acc) begin
                err_map[new_idx] <= 1'b0;
                fail             <= 1'b0;
            end
            if (finish) begin
                unique case (cur_op)
                    OP_RELOAD: begin
                        if (sr_lock[cur_idx]) begin
                            shadow[cur_idx]   <= '0;
                            dist_map[cur_idx] <= 1'b1;
                        end else begin
                            shadow[cur_idx]   <= fuse[cur_idx];
                            dist_map[cur_idx] <= 1'b0;
                        end
                    end
                    OP_PROGRAM: begin
                        if (refuse) fail <= 1'b1;
                        else        fuse[cur_idx] <= fuse[cur_idx] | pdata;
                    end
                    OP_LOCK: lrow[cur_idx[LR_W-1:0]] <= lrow[cur_idx[LR_W-1:0]] | pdata[15:0];
                    default: ;
                endcase
            end
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG:   bus_rdata = {31'b0, pwr_cfg};
            A_PDATA: bus_rdata = pdata;
            A_STAT:  bus_rdata = {26'b0, powered, fail, busy, 3'b0};
            A_GLOCK: bus_rdata = glock;
            default: ;
        endcase
        for (int b = 0; b < NBANKS; b++) begin
            if (bus_addr == A_DIST + ADDR_W'(4 * b)) bus_rdata = dist_map[b*32 +: 32];
            if (bus_addr == A_ERR  + ADDR_W'(4 * b)) bus_rdata = err_map[b*32 +: 32];
            if (bus_addr == A_PERM + ADDR_W'(4 * b)) bus_rdata = perm_map[b*32 +: 32];
            if (bus_addr == A_SPL  + ADDR_W'(4 * b)) bus_rdata = sp_lock[b*32 +: 32];
            if (bus_addr == A_SWL  + ADDR_W'(4 * b)) bus_rdata = sw_lock[b*32 +: 32];
            if (bus_addr == A_SRL  + ADDR_W'(4 * b)) bus_rdata = sr_lock[b*32 +: 32];
        end
        if (sh_sel) bus_rdata = shadow[sh_idx];
    end
endmodule

// File: rtl/otp_shadow_ctrl_chk.sv
module otp_shadow_ctrl_chk #(
    parameter int BMW = 96
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           powered,
    input logic           finish,
    input logic           fail,
    input logic           rej,
    input logic [BMW-1:0] sp_lock,
    input logic [BMW-1:0] sw_lock,
    input logic [BMW-1:0] sr_lock,
    input logic [BMW-1:0] perm_map,
    input logic           glock_prog
);
    assert_start_needs_power_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(powered));

    assert_reject_no_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rej && !busy) |=> !busy);

    assert_fail_from_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(finish));

    assert_sticky_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(sp_lock) & ~sp_lock) | ($past(sw_lock) & ~sw_lock) |
          ($past(sr_lock) & ~sr_lock)) == '0));

    assert_perm_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(perm_map) & ~perm_map) == '0));

    assert_glock_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(glock_prog) |-> glock_prog);
endmodule

bind otp_shadow_ctrl otp_shadow_ctrl_chk #(.BMW(BMW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .powered(powered), .finish(finish),
    .fail(fail), .rej(rej), .sp_lock(sp_lock), .sw_lock(sw_lock),
    .sr_lock(sr_lock), .perm_map(perm_map), .glock_prog(glock[4])
);

// File: tb/tb_otp_shadow_ctrl.sv
module tb_otp_shadow_ctrl;
    localparam int NW = 96, BUSY = 4, PD = 3;
    localparam logic [11:0] CFG = 12'h000, CMD = 12'h004, PDAT = 12'h008, STAT = 12'h00C,
        GLK = 12'h010, DIST = 12'h01C, ERR = 12'h034, PERM = 12'h04C,
        SPL = 12'h064, SWL = 12'h07C, SRL = 12'h094, SHB = 12'h200;

    logic clk = 0, rst_n = 0, bus_en = 0, bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    int errors = 0, checks = 0, cyc = 0;

    logic [31:0] fuse_m [NW];
    logic [31:0] sh_m [NW];
    logic [15:0] lrow_m [8];
    logic [NW-1:0] sp_m = '0, sw_m = '0, sr_m = '0, err_m = '0, dist_m = '0;
    logic glk_m = 0;

    otp_shadow_ctrl #(.NWORDS(NW), .BUSY_CYC(BUSY), .PWR_DLY(PD)) dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic run_cmd(input logic [31:0] c, output int n);
        logic [31:0] s;
        wr(CMD, c); n = 0;
        rd(STAT, s);
        while (s[3]) begin @(negedge clk); n++; rd(STAT, s); end
    endtask

    function automatic logic pm(input int n);
        if (n < 32) return |lrow_m[n/8][(2*n)%16 +: 2];
        return lrow_m[4 + (n-32)/16][n%16];
    endfunction

    function automatic logic [31:0] bank(input logic [NW-1:0] m, input int b);
        return m[b*32 +: 32];
    endfunction

    task automatic prog(input int idx, input logic [31:0] d, input string tag);
        int n; logic [31:0] s; logic f;
        wr(PDAT, d); run_cmd(32'h100 | idx, n);
        f = sp_m[idx] | glk_m | pm(idx);
        if (!f) fuse_m[idx] |= d;
        err_m[idx] = 0;
        rd(STAT, s); chk(tag, {31'b0, s[4]}, {31'b0, f});
    endtask

    task automatic reload(input int idx, input string tag);
        int n; logic [31:0] s;
        run_cmd(idx, n);
        if (sr_m[idx]) begin sh_m[idx] = 0; dist_m[idx] = 1; end
        else begin sh_m[idx] = fuse_m[idx]; dist_m[idx] = 0; end
        err_m[idx] = 0;
        rd(SHB + 12'(4*idx), s); chk(tag, s, sh_m[idx]);
    endtask

    task automatic shw(input int idx, input logic [31:0] d, input string tag);
        logic [31:0] s;
        wr(SHB + 12'(4*idx), d);
        if (!sw_m[idx]) sh_m[idx] = d;
        rd(SHB + 12'(4*idx), s); chk(tag, s, sh_m[idx]);
    endtask

    task automatic set_lock(input logic [11:0] base, input int idx);
        wr(base + 12'(4*(idx>>5)), 32'h1 << (idx & 31));
        if (base == SPL) sp_m[idx] = 1;
        if (base == SWL) sw_m[idx] = 1;
        if (base == SRL) sr_m[idx] = 1;
    endtask

    initial begin
        logic [31:0] s;
        int n;
        for (int i = 0; i < NW; i++) begin fuse_m[i] = 0; sh_m[i] = 0; end
        for (int r = 0; r < 8; r++) lrow_m[r] = 0;
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(STAT, s); chk("R1 status", s, 0);
        rd(SHB + 12'd20, s); chk("R1 shadow", s, 0);
        rd(PERM + 12'd4, s); chk("R1 perm map", s, 0);

        // R9 command while unpowered
        run_cmd(32'd7, n); chk("R9 unpowered no busy", n, 0);
        err_m[7] = 1;
        rd(ERR, s); chk("R9 R11 error bit", s, bank(err_m, 0));

        // R2 power up
        wr(CFG, 1); n = 0; rd(STAT, s);
        while (!s[5] && n < 50) begin @(negedge clk); n++; rd(STAT, s); end
        chk("R2 power-up delay", n, PD + 1);

        // R3 R11 shadow access
        shw(40, 32'hA5A5_0001, "R3 shadow write");
        rd(SHB + 12'hA0, s); chk("R3 R11 shadow offset", s, 32'hA5A5_0001);

        // R5 busy length, R6 program then reload
        wr(PDAT, 32'h0000_00F0); run_cmd(32'h100 | 40, n); fuse_m[40] |= 32'hF0;
        chk("R5 busy cycles", n, BUSY + 1);
        rd(SHB + 12'hA0, s); chk("R6 shadow untouched by program", s, 32'hA5A5_0001);
        reload(40, "R4 R6 reload");
        prog(40, 32'h0F00_0001, "R6 program ok");
        reload(40, "R6 OR accumulate");

        // R9 command while busy, then clearing
        wr(PDAT, 32'h3); wr(CMD, 32'h100 | 41); fuse_m[41] |= 3;
        wr(CMD, 32'd42); err_m[42] = 1;
        repeat (BUSY + 2) @(negedge clk);
        rd(ERR + 12'd4, s); chk("R9 R11 busy reject", s, bank(err_m, 1));
        reload(42, "R9 accepted reload");
        rd(ERR + 12'd4, s); chk("R9 error cleared", s, bank(err_m, 1));

        // R3 R10 shadow-write sticky lock
        set_lock(SWL, 70);
        shw(70, 32'h1234_5678, "R3 locked write ignored");
        wr(SWL + 12'd8, 0);
        rd(SWL + 12'd8, s); chk("R10 sticky kept", s, bank(sw_m, 2));

        // R4 reload lock
        set_lock(SRL, 40);
        reload(40, "R4 reload forced zero");
        rd(DIST + 12'd4, s); chk("R4 R11 disturbed", s, bank(dist_m, 1));

        // R7 R12 program sticky lock
        set_lock(SPL, 41);
        prog(41, 32'hF000_0000, "R7 sticky refuses program");
        reload(41, "R7 fuse unchanged");
        rd(STAT, s); chk("R12 fail cleared", {31'b0, s[4]}, 0);

        // R8 permanent lock encoding
        wr(PDAT, 32'h3 << 10); run_cmd(32'h300, n); lrow_m[0] |= 16'h3 << 10;
        rd(PERM, s); chk("R8 low-density lock", s, 32'h1 << 5);
        wr(PDAT, 32'h1 << 2); run_cmd(32'h300 | 5, n); lrow_m[5] |= 16'h4;
        rd(PERM + 12'd4, s); chk("R8 high-density lock", s, 32'h1 << 18);
        prog(50, 32'h1, "R7 R8 permanent lock refuses");
        prog(5, 32'h1, "R7 R8 low word refuses");

        // random mix
        for (int it = 0; it < 200; it++) begin
            int k; int r;
            k = $urandom % NW; r = $urandom % 8;
            case (r)
                0: if ($urandom % 4 == 0) begin
                       case ($urandom % 3)
                           0: set_lock(SPL, k);
                           1: set_lock(SWL, k);
                           default: set_lock(SRL, k);
                       endcase
                   end
                1, 2: shw(k, $urandom, "R3 random shadow");
                3, 4: prog(k, 32'h1 << ($urandom % 32), "R7 random program");
                5, 6: reload(k, "R4 R6 random reload");
                default: begin
                    rd(DIST + 12'(4*(k>>5)), s); chk("R11 random dist bank", s, bank(dist_m, k>>5));
                end
            endcase
        end

        // R7 R10 global lock
        wr(GLK, 32'h10); glk_m = 1;
        prog(10, 32'h8, "R7 global lock refuses");
        wr(GLK, 0); rd(GLK, s); chk("R10 global lock kept", s, 32'h10);

        // R2 power down then R9 reject
        wr(CFG, 0); n = 0; rd(STAT, s);
        while (s[5] && n < 50) begin @(negedge clk); n++; rd(STAT, s); end
        chk("R2 power-down delay", n, PD + 1);
        run_cmd(32'd3, n); chk("R9 unpowered after drop", n, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule